// File: doc/BRIEF.md
# SPI NAND Flash Command Sequencer

This block sits on the host side of a serial NAND flash that has an on-chip page buffer. A user request selects one of five operations and supplies a page (row) address, a column address and a byte count. The block turns the request into a series of single-bit SPI commands, each in its own chip-select frame. It inserts a write-enable command where one is needed and polls the flash status register until the busy bit clears. It then reports completion with a program-fail or erase-fail flag, or with a timeout flag if the flash stays busy too long.

Array operations take two phases. A page read first moves the array page into the flash buffer, then polls, then streams bytes out of the buffer. A program, or a random-byte load, first fills the buffer, then enables writes, then runs the execute command, then polls. Bytes to be written are pulled from the user one at a time with `wr_take`. Bytes read back are returned one at a time with `rd_valid`.

The controller FSM has these states. T_IDLE waits for a request. T_HDR shifts out the opcode and address bytes. T_WR shifts out user bytes. T_RD shifts in bytes. T_GAP raises chip select for one cycle and picks the next command. T_END pulses `done`. The transitions are: T_IDLE to T_HDR on an accepted request, or to T_END for an unknown opcode. T_HDR goes to T_WR, T_RD or T_GAP after its last header byte. T_WR and T_RD go to T_GAP after their last byte. T_GAP goes to T_HDR for the next command or a repeated poll, or to T_END when the sequence is finished or the timeout has expired. T_END goes to T_IDLE.

The command steps, in order of use, are: LOAD (02h, or 84h for random load), WREN (06h), EXEC (10h), FETCH (13h), POLL (0Fh C0h), BUFRD (03h), ERASE (D8h) and ID (9Fh).

Top module: `snand_seq`

## Requirements
- R1: SPI mode 0. `spi_sclk` is low whenever `spi_cs_n` is high. `spi_mosi` changes only while `spi_sclk` is low. Every byte is sent most significant bit first.
- R2: Page read (`req_op`=0) issues three commands in order. First, FETCH: 13h, 00h, row[15:8], row[7:0]. Second, the POLL commands of R7. Third, BUFRD: 03h, col[15:8], col[7:0], 00h, followed by `req_len` clocked bytes. Each of those bytes is returned on `rd_data`, with `rd_valid` high for one cycle.
- R3: Page program (`req_op`=1) issues four commands in order. First, 02h, col[15:8], col[7:0] and `req_len` bytes taken from `wr_data`, one per `wr_take` pulse. Second, 06h on its own. Third, 10h, 00h, row[15:8], row[7:0]. Fourth, the POLL commands.
- R4: Random load (`req_op`=2) follows the same sequence as R3, except that its first opcode is 84h.
- R5: Block erase (`req_op`=3) issues 06h on its own, then D8h, 00h, row[15:8], row[7:0], then the POLL commands.
- R6: Read ID (`req_op`=4) issues 9Fh, 00h, then clocks two more bytes and returns them on `rd_data` in order.
- R7: A poll is 0Fh, C0h and one returned status byte. Status bit 0 means busy. Bit 2 is erase fail and bit 3 is program fail. The poll repeats in a new frame while bit 0 is set.
- R8: At `done`, `fail` equals status bit 3 for program and random load, and status bit 2 for erase. It is 0 for read and read ID.
- R9: If the cycles spent polling reach `poll_limit` while the busy bit is still set, the sequence ends with `tmo`=1 and `fail`=0.
- R10: Every command is its own frame. `spi_cs_n` goes high for at least one cycle between commands.
- R11: `req_ready` is high only while idle. Each accepted request gives exactly one `done` pulse. A `req_valid` raised while busy is ignored.
- R12: After reset, `spi_cs_n`=1, `spi_sclk`=0, `req_ready`=1 and `done`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | High when a request can be accepted |
| req_op | input | 3 | 0 read, 1 program, 2 random load, 3 erase, 4 read ID |
| req_row | input | 16 | Page address |
| req_col | input | 12 | Column address in the page buffer |
| req_len | input | 12 | Number of data bytes to write or read |
| wr_data | input | 8 | Next byte to write |
| wr_take | output | 1 | `wr_data` consumed this cycle |
| rd_data | output | 8 | Byte read back |
| rd_valid | output | 1 | `rd_data` valid |
| poll_limit | input | 24 | Maximum number of polling cycles |
| done | output | 1 | One-cycle completion pulse |
| fail | output | 1 | Program or erase failure, held until the next request |
| tmo | output | 1 | Polling timeout, held until the next request |
| spi_sclk | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench contains a behavioural flash that logs every frame. It is driven with random and directed requests, including the last column (2111), page 65535 and single-byte transfers. A design that merged commands into one frame, left out the write-enable, or sent address bytes in the wrong order would produce a frame log that differs from the expected log. A long busy period with a small `poll_limit` is used to catch polling that never ends or a timeout reported as a failure. Status bits are set to fail during reads, and a request is raised while the block is busy, to expose a fail flag routed to the wrong operation or a second acceptance.

// File: rtl/snand_pkg.sv
`timescale 1ns/1ps
package snand_pkg;
    typedef enum logic [2:0] {
        OP_PAGE_READ = 3'd0,
        OP_PAGE_PROG = 3'd1,
        OP_RAND_PROG = 3'd2,
        OP_BLK_ERASE = 3'd3,
        OP_READ_ID   = 3'd4
    } req_op_e;

    typedef enum logic [3:0] {
        STP_LOAD, STP_WREN, STP_EXEC, STP_FETCH, STP_POLL,
        STP_BUFRD, STP_ERASE, STP_ID, STP_FIN
    } step_e;

    typedef enum logic [2:0] {
        T_IDLE, T_HDR, T_WR, T_RD, T_GAP, T_END
    } tstate_e;

    localparam logic [7:0] CMD_LOAD    = 8'h02;
    localparam logic [7:0] CMD_RLOAD   = 8'h84;
    localparam logic [7:0] CMD_WREN    = 8'h06;
    localparam logic [7:0] CMD_EXEC    = 8'h10;
    localparam logic [7:0] CMD_FETCH   = 8'h13;
    localparam logic [7:0] CMD_GETFEAT = 8'h0F;
    localparam logic [7:0] FEAT_STATUS = 8'hC0;
    localparam logic [7:0] CMD_BUFRD   = 8'h03;
    localparam logic [7:0] CMD_ERASE   = 8'hD8;
    localparam logic [7:0] CMD_ID      = 8'h9F;

    localparam int ST_BUSY  = 0;
    localparam int ST_EFAIL = 2;
    localparam int ST_PFAIL = 3;
endpackage

// File: rtl/snand_byte_shifter.sv
`timescale 1ns/1ps
module snand_byte_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi,
    input  logic       miso
);
    logic [7:0] tx_q;
    logic [2:0] bit_q;
    logic       ph_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            done    <= 1'b0;
            tx_q    <= '0;
            rx_byte <= '0;
            bit_q   <= '0;
            ph_q    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy  <= 1'b1;
                    tx_q  <= tx_byte;
                    bit_q <= '0;
                    ph_q  <= 1'b0;
                end
            end else if (!ph_q) begin
                ph_q <= 1'b1;
            end else begin
                ph_q    <= 1'b0;
                rx_byte <= {rx_byte[6:0], miso};
                tx_q    <= {tx_q[6:0], 1'b0};
                bit_q   <= bit_q + 3'd1;
                if (bit_q == 3'd7) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign sclk = ph_q;
    assign mosi = tx_q[7];

    // R1: data line holds while the clock is high
    p_mosi_steady_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk) |-> $stable(mosi));
endmodule

// File: rtl/snand_poll_timer.sv
`timescale 1ns/1ps
module snand_poll_timer #(
    parameter int TMO_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             run,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);
    logic [TMO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clr)              cnt_q <= '0;
        else if (run && !expired)  cnt_q <= cnt_q + 1'b1;
    end

    assign expired = (cnt_q >= limit);

    // R9: once the budget is spent it stays spent until cleared
    p_expiry_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr && $stable(limit)) |=> expired);
endmodule

// File: rtl/snand_seq.sv
`timescale 1ns/1ps
module snand_seq
    import snand_pkg::*;
#(
    parameter int ROW_W = 16,
    parameter int COL_W = 12,
    parameter int LEN_W = 12,
    parameter int TMO_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_op,
    input  logic [ROW_W-1:0] req_row,
    input  logic [COL_W-1:0] req_col,
    input  logic [LEN_W-1:0] req_len,
    input  logic [7:0]       wr_data,
    output logic             wr_take,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic [TMO_W-1:0] poll_limit,
    output logic             done,
    output logic             fail,
    output logic             tmo,
    output logic             spi_sclk,
    output logic             spi_cs_n,
    output logic             spi_mosi,
    input  logic             spi_miso
);
    tstate_e          state_q, state_d;
    step_e            step_q, step_d, first_c, next_c;
    req_op_e          op_q;
    logic [LEN_W-1:0] idx_q, idx_d, len_q, dcnt_c;
    logic [15:0]      row16, col16;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;
    logic [2:0]       hlen_c;
    logic [7:0]       hbyte_c, eng_tx, eng_rx;
    logic             eng_start, eng_busy, eng_done, in_frame, tmr_exp;
    logic             st_busy_q, st_efail_q, st_pfail_q, fail_q, tmo_q;
    logic             accept;

    assign row16  = 16'(row_q);
    assign col16  = 16'(col_q);
    assign accept = req_valid && (state_q == T_IDLE);

    // header bytes and data count per step
    always_comb begin
        hlen_c  = 3'd4;
        hbyte_c = 8'h00;
        dcnt_c  = '0;
        unique case (step_q)
            STP_LOAD: begin
                hlen_c = 3'd3;
                dcnt_c = len_q;
                unique case (idx_q[1:0])
                    2'd0:    hbyte_c = (op_q == OP_RAND_PROG) ? CMD_RLOAD : CMD_LOAD;
                    2'd1:    hbyte_c = col16[15:8];
                    default: hbyte_c = col16[7:0];
                endcase
            end
            STP_WREN: begin hlen_c = 3'd1; hbyte_c = CMD_WREN; end
            STP_EXEC, STP_FETCH, STP_ERASE: begin
                unique case (idx_q[1:0])
                    2'd0:    hbyte_c = (step_q == STP_EXEC)  ? CMD_EXEC :
                                       (step_q == STP_FETCH) ? CMD_FETCH : CMD_ERASE;
                    2'd1:    hbyte_c = 8'h00;
                    2'd2:    hbyte_c = row16[15:8];
                    default: hbyte_c = row16[7:0];
                endcase
            end
            STP_POLL: begin
                hlen_c  = 3'd2;
                dcnt_c  = LEN_W'(1);
                hbyte_c = idx_q[0] ? FEAT_STATUS : CMD_GETFEAT;
            end
            STP_BUFRD: begin
                dcnt_c = len_q;
                unique case (idx_q[1:0])
                    2'd0:    hbyte_c = CMD_BUFRD;
                    2'd1:    hbyte_c = col16[15:8];
                    2'd2:    hbyte_c = col16[7:0];
                    default: hbyte_c = 8'h00;
                endcase
            end
            STP_ID: begin
                hlen_c  = 3'd2;
                dcnt_c  = LEN_W'(2);
                hbyte_c = idx_q[0] ? 8'h00 : CMD_ID;
            end
            default: hlen_c = 3'd1;
        endcase
    end

    // step ordering
    always_comb begin
        unique case (req_op_e'(req_op))
            OP_PAGE_READ:               first_c = STP_FETCH;
            OP_PAGE_PROG, OP_RAND_PROG: first_c = STP_LOAD;
            OP_BLK_ERASE:               first_c = STP_WREN;
            OP_READ_ID:                 first_c = STP_ID;
            default:                    first_c = STP_FIN;
        endcase
        unique case (step_q)
            STP_LOAD:  next_c = STP_WREN;
            STP_WREN:  next_c = (op_q == OP_BLK_ERASE) ? STP_ERASE : STP_EXEC;
            STP_EXEC, STP_FETCH, STP_ERASE: next_c = STP_POLL;
            STP_POLL:  next_c = (op_q == OP_PAGE_READ) ? STP_BUFRD : STP_FIN;
            default:   next_c = STP_FIN;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        idx_d   = idx_q;
        unique case (state_q)
            T_IDLE: if (req_valid) begin
                step_d  = first_c;
                idx_d   = '0;
                state_d = (first_c == STP_FIN) ? T_END : T_HDR;
            end
            T_HDR: if (eng_done) begin
                if ((idx_q + 1'b1) == LEN_W'(hlen_c)) begin
                    idx_d = '0;
                    if (dcnt_c == '0)            state_d = T_GAP;
                    else if (step_q == STP_LOAD) state_d = T_WR;
                    else                         state_d = T_RD;
                end else idx_d = idx_q + 1'b1;
            end
            T_WR, T_RD: if (eng_done) begin
                if ((idx_q + 1'b1) == dcnt_c) begin
                    idx_d   = '0;
                    state_d = T_GAP;
                end else idx_d = idx_q + 1'b1;
            end
            T_GAP: begin
                if (step_q == STP_POLL && st_busy_q) begin
                    state_d = tmr_exp ? T_END : T_HDR;
                end else if (next_c == STP_FIN) begin
                    state_d = T_END;
                end else begin
                    step_d  = next_c;
                    state_d = T_HDR;
                end
            end
            T_END:   state_d = T_IDLE;
            default: state_d = T_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= T_IDLE;
            step_q  <= STP_FIN;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            idx_q   <= idx_d;
        end
    end

    // request fields, status and results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q <= OP_PAGE_READ;
            row_q <= '0; col_q <= '0; len_q <= '0;
            st_busy_q <= 1'b0; st_efail_q <= 1'b0; st_pfail_q <= 1'b0;
            fail_q <= 1'b0; tmo_q <= 1'b0;
            rd_data <= '0; rd_valid <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            if (accept) begin
                op_q <= req_op_e'(req_op);
                row_q <= req_row; col_q <= req_col; len_q <= req_len;
                st_busy_q <= 1'b0; fail_q <= 1'b0; tmo_q <= 1'b0;
            end
            if (state_q == T_RD && eng_done) begin
                if (step_q == STP_POLL) begin
                    st_busy_q  <= eng_rx[ST_BUSY];
                    st_efail_q <= eng_rx[ST_EFAIL];
                    st_pfail_q <= eng_rx[ST_PFAIL];
                end else begin
                    rd_data  <= eng_rx;
                    rd_valid <= 1'b1;
                end
            end
            if (state_q == T_GAP && step_q == STP_POLL) begin
                if (st_busy_q) tmo_q <= tmr_exp;
                else if (op_q == OP_PAGE_PROG || op_q == OP_RAND_PROG) fail_q <= st_pfail_q;
                else if (op_q == OP_BLK_ERASE) fail_q <= st_efail_q;
            end
        end
    end

    // outputs
    always_comb begin
        in_frame  = (state_q == T_HDR) || (state_q == T_WR) || (state_q == T_RD);
        eng_start = in_frame && !eng_busy && !eng_done;
        eng_tx    = (state_q == T_HDR) ? hbyte_c : (state_q == T_WR) ? wr_data : 8'h00;
        wr_take   = eng_start && (state_q == T_WR);
        spi_cs_n  = !in_frame;
        req_ready = (state_q == T_IDLE);
        done      = (state_q == T_END);
        fail      = fail_q;
        tmo       = tmo_q;
    end

    snand_byte_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .start(eng_start), .tx_byte(eng_tx),
        .busy(eng_busy), .done(eng_done), .rx_byte(eng_rx),
        .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso)
    );

    snand_poll_timer #(.TMO_W(TMO_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(state_q == T_IDLE),
        .run(step_q == STP_POLL), .limit(poll_limit), .expired(tmr_exp)
    );

    // R1: clock parked low outside a frame
    p_sclk_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sclk);
    // R11: an accepted request opens a frame on the next cycle
    p_frame_open_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !spi_cs_n);
    // R11: completion returns to idle
    p_idle_after_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);
    // R9: timeout and failure never reported together
    p_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !(fail && tmo));
endmodule

// File: tb/snand_seq_tb_top.sv
`timescale 1ns/1ps
module snand_seq_tb_top;
    logic clk = 1'b0;
    always #5 clk = ~clk;
    logic rst_n = 1'b0;

    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_op = '0;
    logic [15:0] req_row = '0;
    logic [11:0] req_col = '0;
    logic [11:0] req_len = '0;
    logic [7:0]  wr_data;
    logic        wr_take;
    logic [7:0]  rd_data;
    logic        rd_valid;
    logic [23:0] poll_limit = 24'd100000;
    logic        done, fail, tmo, spi_sclk, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    snand_seq dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_row(req_row), .req_col(req_col), .req_len(req_len),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .poll_limit(poll_limit), .done(done), .fail(fail), .tmo(tmo),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    int checks = 0, failures = 0;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // user-side streams
    logic [7:0] wbuf [0:63];
    logic [7:0] rcv  [0:63];
    int wptr = 0, wbase = 0, rcnt = 0, rbase = 0, done_cnt = 0;
    bit last_fail = 0, last_tmo = 0;
    assign wr_data = wbuf[(wptr - wbase) & 63];
    always @(posedge clk) begin
        if (wr_take) wptr <= wptr + 1;
        if (rd_valid) begin
            rcv[(rcnt - rbase) & 63] <= rd_data;
            rcnt <= rcnt + 1;
        end
        if (done) begin
            done_cnt  <= done_cnt + 1;
            last_fail <= fail;
            last_tmo  <= tmo;
        end
    end

    // bus-level monitors (R1, R10)
    int idle_viol = 0, cs_hi_run = 0, cs_hi_min = 1000;
    logic prev_mosi = 1'b0, prev_sclk = 1'b0;
    always @(negedge clk) if (rst_n) begin
        if (spi_cs_n && spi_sclk) idle_viol++;
        if (prev_sclk && spi_sclk && spi_mosi != prev_mosi) idle_viol++;
        if (spi_cs_n) cs_hi_run++;
        else begin
            if (cs_hi_run > 0 && cs_hi_run < cs_hi_min) cs_hi_min = cs_hi_run;
            cs_hi_run = 0;
        end
        prev_mosi = spi_mosi;
        prev_sclk = spi_sclk;
    end

    // behavioural flash
    int cfg_busy = 0;
    bit cfg_pf = 0, cfg_ef = 0;
    int totbits = 0, busy_left = 0, nfrm = 0;
    bit in_frm = 0, wel = 0;
    logic [7:0] sh = '0;
    logic [7:0] cur [0:63];
    logic [15:0] fetch_row = '0;
    logic [7:0] logf [0:31][0:63];
    int logn [0:31];

    function automatic logic [7:0] pat(input logic [15:0] r, input int c);
        return (r[7:0] * 8'd29) ^ r[15:8] ^ c[7:0] ^ {c[11:8], 4'h9};
    endfunction

    function automatic logic [7:0] resp_byte(input int k);
        if (k >= 64) return 8'h00;
        if (cur[0] == 8'h0F && k == 2) return {4'b0, cfg_pf, cfg_ef, wel, busy_left > 0};
        if (cur[0] == 8'h9F && k == 2) return 8'hA5;
        if (cur[0] == 8'h9F && k == 3) return 8'h3C;
        if (cur[0] == 8'h03 && k >= 4) return pat(fetch_row, int'({cur[1], cur[2]}) + k - 4);
        return 8'h00;
    endfunction

    always @(negedge spi_cs_n) if (rst_n) begin in_frm = 1; totbits = 0; end
    always @(posedge spi_sclk) if (in_frm) begin
        sh = {sh[6:0], spi_mosi};
        totbits++;
        if (totbits % 8 == 0 && totbits <= 512) cur[totbits/8 - 1] = sh;
    end
    always @(negedge spi_sclk) if (in_frm) begin
        logic [7:0] rb;
        rb = resp_byte(totbits / 8);
        spi_miso = rb[7 - (totbits % 8)];
    end
    always @(posedge spi_cs_n) if (in_frm) begin
        in_frm = 0;
        logn[nfrm & 31] = totbits / 8;
        for (int i = 0; i < 64; i++) logf[nfrm & 31][i] = cur[i];
        case (cur[0])
            8'h06: wel = 1;
            8'h10, 8'hD8: begin wel = 0; busy_left = cfg_busy; end
            8'h13: begin fetch_row = {cur[2], cur[3]}; busy_left = cfg_busy; end
            8'h0F: if (busy_left > 0) busy_left--;
            default: ;
        endcase
        nfrm++;
    end

    // expected frames
    logic [7:0] expf [0:31][0:63];
    int expn [0:31];
    int nexp = 0;
    task automatic ef_put(input logic [7:0] b);
        if (expn[nexp] < 64) expf[nexp][expn[nexp]] = b;
        expn[nexp]++;
    endtask
    task automatic ef_next(); nexp++; expn[nexp] = 0; endtask
    task automatic ef_polls(input int busy);
        for (int p = 0; p <= busy; p++) begin
            ef_put(8'h0F); ef_put(8'hC0); ef_put(8'h00); ef_next();
        end
    endtask
    task automatic ef_row(input logic [7:0] opc, input logic [15:0] row);
        ef_put(opc); ef_put(8'h00); ef_put(row[15:8]); ef_put(row[7:0]); ef_next();
    endtask

    task automatic build_exp(input int op, input logic [15:0] row, input logic [11:0] col, input int len, input int busy);
        nexp = 0; expn[0] = 0;
        case (op)
            0: begin
                ef_row(8'h13, row); ef_polls(busy);
                ef_put(8'h03); ef_put({4'h0, col[11:8]}); ef_put(col[7:0]); ef_put(8'h00);
                for (int i = 0; i < len; i++) ef_put(8'h00);
                ef_next();
            end
            1, 2: begin
                ef_put(op == 1 ? 8'h02 : 8'h84); ef_put({4'h0, col[11:8]}); ef_put(col[7:0]);
                for (int i = 0; i < len; i++) ef_put(wbuf[i]);
                ef_next();
                ef_put(8'h06); ef_next();
                ef_row(8'h10, row); ef_polls(busy);
            end
            3: begin ef_put(8'h06); ef_next(); ef_row(8'hD8, row); ef_polls(busy); end
            default: begin ef_put(8'h9F); ef_put(8'h00); ef_put(8'h00); ef_put(8'h00); ef_next(); end
        endcase
    endtask

    function automatic string optag(input int op);
        case (op)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    int fbase = 0;
    task automatic issue(input int op, input logic [15:0] row, input logic [11:0] col, input int len,
                         input int busy, input bit pf, input bit ef, input int lim, input bit poke);
        int d0;
        cfg_busy = busy; cfg_pf = pf; cfg_ef = ef;
        for (int i = 0; i < 64; i++) wbuf[i] = 8'($urandom);
        @(negedge clk);
        wbase = wptr; rbase = rcnt; fbase = nfrm; d0 = done_cnt;
        poll_limit = 24'(lim);
        req_op = 3'(op); req_row = row; req_col = col; req_len = 12'(len);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            repeat (20) @(negedge clk);
            check(!req_ready, "R11", "ready while busy", req_ready, 0);
            req_op = 3'd3; req_row = ~row; req_valid = 1'b1;
            repeat (2) @(negedge clk);
            req_valid = 1'b0;
        end
        while (done_cnt == d0) @(negedge clk);
        repeat (4) @(negedge clk);
        check(done_cnt - d0 == 1, "R11", "done pulses", done_cnt - d0, 1);
        check(req_ready, "R11", "ready after done", req_ready, 1);
    endtask

    task automatic verify(input int op, input logic [15:0] row, input logic [11:0] col, input int len,
                          input int busy, input bit pf, input bit ef);
        bit ok;
        int bad;
        bit efail;
        string t;
        t = optag(op);
        build_exp(op, row, col, len, busy);
        check(nfrm - fbase == nexp, "R10", {t, " frame count"}, nfrm - fbase, nexp);
        for (int f = 0; f < nexp && f < nfrm - fbase; f++) begin
            ok = (logn[(fbase + f) & 31] == expn[f]);
            bad = -1;
            for (int b = 0; b < expn[f] && b < 64; b++)
                if (ok && logf[(fbase + f) & 31][b] != expf[f][b]) begin ok = 0; bad = b; end
            if (bad >= 0)
                check(0, (expf[f][0] == 8'h0F) ? "R7" : t, $sformatf("frame %0d byte %0d", f, bad),
                      logf[(fbase + f) & 31][bad], expf[f][bad]);
            else
                check(ok, (expf[f][0] == 8'h0F) ? "R7" : t, $sformatf("frame %0d length", f),
                      logn[(fbase + f) & 31], expn[f]);
        end
        if (op == 0) begin
            check(rcnt - rbase == len, "R2", "bytes returned", rcnt - rbase, len);
            for (int i = 0; i < len && i < 64; i++)
                if (rcv[i] != pat(row, int'(col) + i))
                    check(0, "R2", $sformatf("read byte %0d", i), rcv[i], pat(row, int'(col) + i));
            check(1, "R2", "read data", 0, 0);
        end
        if (op == 4) begin
            check(rcnt - rbase == 2, "R6", "id byte count", rcnt - rbase, 2);
            check(rcv[0] == 8'hA5 && rcv[1] == 8'h3C, "R6", "id bytes", {rcv[0], rcv[1]}, 16'hA53C);
        end
        efail = (op == 1 || op == 2) ? pf : (op == 3) ? ef : 1'b0;
        check(last_fail == efail, "R8", {t, " fail flag"}, last_fail, efail);
        check(!last_tmo, "R9", "no timeout", last_tmo, 0);
    endtask

    task automatic op_run(input int op, input logic [15:0] row, input logic [11:0] col, input int len,
                          input int busy, input bit pf, input bit ef, input bit poke);
        issue(op, row, col, len, busy, pf, ef, 100000, poke);
        verify(op, row, col, len, busy, pf, ef);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check(spi_cs_n == 1'b1, "R12", "cs_n after reset", spi_cs_n, 1);
        check(spi_sclk == 1'b0, "R12", "sclk after reset", spi_sclk, 0);
        check(req_ready == 1'b1, "R12", "ready after reset", req_ready, 1);
        check(done == 1'b0, "R12", "done after reset", done, 0);

        // directed corners
        op_run(0, 16'hFFFF, 12'd2111, 1, 2, 1, 1, 0);   // last page/column, fail bits ignored on read
        op_run(1, 16'h1234, 12'd0, 5, 1, 1, 0, 0);      // program failure
        op_run(2, 16'h00C0, 12'd2047, 3, 0, 0, 1, 0);   // random load, no busy
        op_run(3, 16'h0040, 12'd0, 0, 3, 0, 1, 0);      // erase failure
        op_run(4, 16'h0000, 12'd0, 0, 0, 1, 1, 0);      // ID
        op_run(1, 16'h7777, 12'd100, 4, 2, 0, 0, 1);    // R11 request while busy ignored

        // R9 timeout: flash stays busy beyond a short budget
        issue(3, 16'h0080, 12'd0, 0, 1000, 0, 1, 300, 0);
        check(last_tmo == 1'b1, "R9", "timeout flag", last_tmo, 1);
        check(last_fail == 1'b0, "R9", "fail with timeout", last_fail, 0);
        check(logf[(nfrm - 1) & 31][0] == 8'h0F, "R7", "last frame is poll", logf[(nfrm - 1) & 31][0], 8'h0F);
        check(nfrm - fbase >= 4, "R7", "repeated polls", nfrm - fbase, 4);

        // random mix
        for (int n = 0; n < 14; n++) begin
            int op, len, busy;
            logic [15:0] row;
            logic [11:0] col;
            op = $urandom_range(0, 4);
            row = 16'($urandom_range(0, 65535));
            col = 12'($urandom_range(0, 2111));
            len = $urandom_range(1, 24);
            busy = $urandom_range(0, 3);
            op_run(op, row, col, len, busy, 1'($urandom), 1'($urandom), 0);
        end

        check(idle_viol == 0, "R1", "mode 0 idle/stability violations", idle_viol, 0);
        check(cs_hi_min >= 1, "R10", "min cs high cycles", cs_hi_min, 1);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule